// File: doc/BRIEF.md
# Interrupt Mask and Serial-Out Control

This block sits beside a processor core. It gates three vectored interrupt requests and holds a one-bit serial output. Two of the requests are level-sensed: a higher-priority one and a lower-priority one. The third is captured by rising edge into a latch, which holds the request until it is serviced or cancelled.

A single write strobe carries an 8-bit accumulator value. Enable bits inside that value decide which parts of the write take effect: the three mask bits, a software clear of the edge latch, and the serial output bit. The core also supplies a global interrupt-enable flag and an acknowledge for the edge request.

The block reports, without a clock delay, which requests are serviceable and which one has the highest priority. It also offers a status byte for the core to read.

Top module: `intmask_ctl`

## Requirements
- R1: After reset, all three masks are 1, the edge latch is clear and `ser_out` is 0.
- R2: A write with data bit 3 = 1 loads the masks from data bits 2 (edge), 1 (high level) and 0 (low level). A write with bit 3 = 0 leaves all masks unchanged, whatever bits 2..0 hold.
- R3: A write with data bit 6 = 1 copies data bit 7 to `ser_out` at the next clock edge. A write with bit 6 = 0 leaves `ser_out` unchanged.
- R4: A write with data bit 4 = 1 clears the edge latch.
- R5: `irq_edge_in` passes through two synchronizer flops, and a rising edge is detected on the synchronized value. The latch becomes visible at the third rising clock edge after the pin rises. It stays set after the pin falls, and a pin held high does not set it again.
- R6: The edge latch is set regardless of the mask bits and of `int_en`.
- R7: `svc_edge`, `svc_hi` and `svc_lo` are each high only when the request is pending, its mask is 0 and `int_en` is 1. Level requests are pending while their input pin is high. A mask value of 1 means unavailable.
- R8: `edge_ack` clears the edge latch.
- R9: A rising edge detected in the same cycle as an acknowledge or a bit-4 clear sets the latch; the new edge wins.
- R10: `svc_top` is one-hot or zero and marks the highest-priority serviceable request: bit 2 = edge, bit 1 = high level, bit 0 = low level. Edge has the highest priority.
- R11: The `status` layout is: [2:0] masks (edge, high, low), [3] `int_en`, [4] low pin, [5] high pin, [6] edge latch, [7] `ser_in`.
- R12: Writing 0x1C discards a pending edge request and masks the edge input. A later edge sets the latch but is not serviceable while the mask stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Accumulator value for the write |
| int_en | input | 1 | Global interrupt enable |
| irq_edge_in | input | 1 | Edge-triggered request pin (asynchronous) |
| irq_hi_in | input | 1 | Higher-priority level request |
| irq_lo_in | input | 1 | Lower-priority level request |
| edge_ack | input | 1 | Acknowledge of the edge request |
| ser_in | input | 1 | Serial input sample reported in status |
| ser_out | output | 1 | Serial output latch |
| svc_edge | output | 1 | Edge request serviceable |
| svc_hi | output | 1 | High-level request serviceable |
| svc_lo | output | 1 | Low-level request serviceable |
| svc_top | output | 3 | One-hot highest-priority serviceable request |
| status | output | 8 | Readable status byte |

## Verification
The hardest case to reach is an acknowledge or software clear that lands in exactly the cycle the synchronized edge is detected. The bench counts clock edges after raising the pin and asserts the acknowledge in the second cycle, which is the one where the detector fires. It then checks that the latch stays set. The edge latch is also set while masked and with the global enable off, then unmasked, to show that it captured the request independently of both.

// File: rtl/intmask_ctl.sv
module intmask_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       int_en,
  input  logic       irq_edge_in,
  input  logic       irq_hi_in,
  input  logic       irq_lo_in,
  input  logic       edge_ack,
  input  logic       ser_in,
  output logic       ser_out,
  output logic       svc_edge,
  output logic       svc_hi,
  output logic       svc_lo,
  output logic [2:0] svc_top,
  output logic [7:0] status
);
  logic [2:0] mask;
  logic [2:0] sync;
  logic       edge_pend;
  logic       rise;
  logic       sw_clear;

  assign rise     = sync[1] & ~sync[2];
  assign sw_clear = wr_en & wr_data[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask      <= 3'b111;
      ser_out   <= 1'b0;
      sync      <= 3'b000;
      edge_pend <= 1'b0;
    end else begin
      sync <= {sync[1:0], irq_edge_in};
      if (wr_en && wr_data[3]) mask <= wr_data[2:0];
      if (wr_en && wr_data[6]) ser_out <= wr_data[7];
      if (rise) edge_pend <= 1'b1;
      else if (edge_ack || sw_clear) edge_pend <= 1'b0;
    end
  end

  assign svc_edge = edge_pend & ~mask[2] & int_en;
  assign svc_hi   = irq_hi_in & ~mask[1] & int_en;
  assign svc_lo   = irq_lo_in & ~mask[0] & int_en;

  assign svc_top = svc_edge ? 3'b100 :
                   svc_hi   ? 3'b010 :
                   svc_lo   ? 3'b001 : 3'b000;

  assign status = {ser_in, edge_pend, irq_hi_in, irq_lo_in, int_en, mask};
endmodule

module intmask_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       int_en,
  input logic       edge_ack,
  input logic       ser_out,
  input logic       svc_edge,
  input logic       svc_hi,
  input logic       svc_lo,
  input logic [2:0] svc_top,
  input logic [7:0] status
);
  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[3]) |=> $stable(status[2:0]));
  assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[3]) |=> status[2:0] == $past(wr_data[2:0]));
  assert_ser_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[6]) |=> $stable(ser_out));
  assert_ser_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[6]) |=> ser_out == $past(wr_data[7]));
  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6] && !edge_ack && !(wr_en && wr_data[4])) |=> status[6]);
  assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !(svc_edge || svc_hi || svc_lo));
  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(svc_top));
  assert_edge_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    svc_edge |-> svc_top == 3'b100);
endmodule

bind intmask_ctl intmask_ctl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .int_en(int_en),
  .edge_ack(edge_ack), .ser_out(ser_out), .svc_edge(svc_edge), .svc_hi(svc_hi),
  .svc_lo(svc_lo), .svc_top(svc_top), .status(status)
);

// File: tb/test_intmask_ctl.sv
`timescale 1ns/1ps
module test_intmask_ctl;
  logic clk = 0, rst_n = 0, wr_en = 0, int_en = 0;
  logic irq_edge_in = 0, irq_hi_in = 0, irq_lo_in = 0, edge_ack = 0, ser_in = 0;
  logic [7:0] wr_data = 0;
  logic ser_out, svc_edge, svc_hi, svc_lo;
  logic [2:0] svc_top;
  logic [7:0] status;

  always #2 clk = ~clk;

  intmask_ctl i_intmask_ctl (.*);

  typedef struct {
    string      req;
    logic [7:0] st;
    logic [2:0] svc;
    logic [2:0] top;
    logic       so;
  } item_t;
  item_t q[$];

  int checks = 0, errors = 0;
  logic [2:0] m_mask = 3'b111;
  logic       m_latch = 0, m_ser = 0;
  bit         done = 0;

  task automatic step(); @(posedge clk); #1; endtask

  task automatic push(string req);
    item_t it;
    logic [2:0] s;
    s[2] = m_latch & ~m_mask[2] & int_en;
    s[1] = irq_hi_in & ~m_mask[1] & int_en;
    s[0] = irq_lo_in & ~m_mask[0] & int_en;
    it.req = req;
    it.st  = {ser_in, m_latch, irq_hi_in, irq_lo_in, int_en, m_mask};
    it.svc = s;
    it.top = s[2] ? 3'b100 : s[1] ? 3'b010 : s[0] ? 3'b001 : 3'b000;
    it.so  = m_ser;
    q.push_back(it);
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1; wr_data = d;
    step();
    wr_en = 0; wr_data = 0;
    if (d[3]) m_mask = d[2:0];
    if (d[6]) m_ser = d[7];
    if (d[4]) m_latch = 0;
  endtask

  task automatic edge_up();
    irq_edge_in = 1; step(); step(); step();
    m_latch = 1;
  endtask

  task automatic edge_down();
    irq_edge_in = 0; step(); step(); step();
  endtask

  always begin
    @(negedge clk);
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (status !== it.st || {svc_edge, svc_hi, svc_lo} !== it.svc ||
          svc_top !== it.top || ser_out !== it.so) begin
        errors++;
        $display("FAIL %s: status=%h svc=%b top=%b ser=%b expected status=%h svc=%b top=%b ser=%b",
                 it.req, status, {svc_edge, svc_hi, svc_lo}, svc_top, ser_out,
                 it.st, it.svc, it.top, it.so);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1; ser_in = 1;
    step();
    push("R1 R11 reset state");
    step();
    int_en = 1; irq_hi_in = 1; irq_lo_in = 1;
    push("R7 masks at 1 block service");
    step();
    wr(8'h0B);
    push("R2 masks loaded 011");
    step();
    wr(8'h07);
    push("R2 bit3 clear leaves masks");
    step();
    wr(8'h08);
    push("R7 R10 both levels, high wins");
    step();
    irq_hi_in = 0;
    push("R10 low wins when high idle");
    step();
    int_en = 0;
    push("R7 global disable");
    step();
    wr(8'hC0);
    push("R3 serial bit loads 1");
    step();
    wr(8'h40);
    push("R3 serial bit loads 0");
    step();
    wr(8'h80);
    push("R3 bit6 clear holds serial");
    step();
    wr(8'h0C);
    edge_up();
    push("R5 R6 latch set while masked and disabled");
    step();
    step(); step(); step();
    push("R5 held high does not re-set");
    edge_down();
    push("R5 latch holds after pin falls");
    step();
    irq_lo_in = 1; int_en = 1;
    wr(8'h08);
    push("R10 R7 edge beats low level");
    step();
    edge_ack = 1; step(); edge_ack = 0; m_latch = 0;
    push("R8 acknowledge clears");
    step();
    edge_up();
    edge_down();
    wr(8'h10);
    push("R4 bit4 write clears latch");
    step();
    irq_edge_in = 1; step(); step();
    edge_ack = 1; step(); edge_ack = 0; m_latch = 1;
    push("R9 edge wins over ack");
    step();
    edge_down();
    irq_edge_in = 1; step(); step();
    wr(8'h10); m_latch = 1;
    push("R9 edge wins over bit4 clear");
    step();
    edge_down();
    wr(8'h1C);
    push("R12 0x1C discards and masks");
    step();
    edge_up();
    push("R12 later edge stays unserviceable");
    step();
    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule